// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block keeps the machine-level control and status registers of a small 32-bit core with two privilege levels, machine and user. It also carries out trap entry and trap return. The pipeline gives it a CSR access port, a synchronous exception request with its cause and trap value, the PC of the instruction that is retiring, an environment-call strobe and a trap-return strobe. At the next clock edge the block updates its registers and privilege. In the cycle after that it presents a one-cycle redirect with the new fetch address.

Three kinds of event enter a trap: an exception request, an environment call, and a trap return attempted from user mode. The last of these is turned into an illegal-instruction trap inside the block and is also flagged on a port. The trap vector base can be used in direct or vectored form. Only interrupt causes are spread across vector slots. The access port has a read-enable input. When that input is low, the access writes without a read: the read data bus stays at zero, which covers a write whose destination register is x0.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset the privilege is machine (3), every writable register reads 0, and redirect_valid and illegal are 0.
- R2: Reads return combinationally for the address on csr_addr. 0x301 returns 0x40100100. 0xF13 returns 1. 0xF11, 0xF12, 0xF14 and any unmapped address return 0. csr_rdata is 0 whenever csr_re is low.
- R3: A write takes effect at the next clock edge. 0x304, 0x305, 0x341, 0x342, 0x343 and 0x344 store all 32 bits. At 0x300, only bit 3 (interrupt enable), bit 7 (previous enable) and bits 12:11 (previous privilege) are stored, and all other bits read 0. A previous-privilege value of 1 or 2 is stored as 0.
- R4: An exception request is taken whatever the value of bit 3. At the edge the block does all of the following: 0x341 takes pc, 0x342 takes exc_cause, 0x343 takes exc_tval, bit 7 takes bit 3, bit 3 clears, bits 12:11 take the privilege, and the privilege becomes machine.
- R5: The redirect target is 0x305 with bits 1:0 cleared. When 0x305 bits 1:0 equal 1 and cause bit 31 (interrupt) is set, 4 times cause bits 30:0 is added to that base.
- R6: An environment call takes a trap with cause 8 from user mode and 11 from machine mode, with trap value 0.
- R7: A trap return in machine mode sets bit 3 from bit 7, sets bit 7 to 1, sets the privilege from bits 12:11, sets bits 12:11 to 0, and redirects to the value 0x341 held before the edge.
- R8: A trap return in user mode pulses illegal and takes a trap with cause 2, trap value 0 and 0x341 equal to pc.
- R9: Priority is exception request, then environment call, then trap return. A CSR write in the same cycle as any of these is dropped.
- R10: redirect_valid is high for exactly the one cycle after each taken event, with redirect_pc valid in that cycle. It is low after any cycle without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_re | input | 1 | CSR read enable; low gives zero read data |
| csr_rdata | output | 32 | CSR read data |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 32 | Cause value, bit 31 marks an interrupt |
| exc_tval | input | 32 | Trap value |
| pc | input | 32 | PC of the retiring instruction |
| ecall | input | 1 | Environment-call strobe |
| mret | input | 1 | Trap-return strobe |
| redirect_pc | output | 32 | New fetch address |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| priv | output | 2 | Current privilege, 0 user, 3 machine |
| illegal | output | 1 | Pulse for a trap return from user mode |

## Verification
Suppose a save or restore step stores the wrong value, for example a swapped enable bit, a stale privilege or a wrong exception PC. The error stays hidden until a later read of 0x300 or 0x341 shows it. It also shows when a trap return comes back at the wrong privilege or address. So the stimulus reads the state back right after each trap and chains trap and return sequences. A wrong vector computation or a wrong priority choice shows on redirect_pc, or as a missing pulse, in the cycle right after the event.

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit #(
  parameter logic [31:0] HART_ID  = 32'd0,
  parameter logic [31:0] IMPL_ID  = 32'd1,
  parameter logic [31:0] ISA_WORD = 32'h4010_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  input  logic        csr_we,
  input  logic        csr_re,
  output logic [31:0] csr_rdata,
  input  logic        exc_req,
  input  logic [31:0] exc_cause,
  input  logic [31:0] exc_tval,
  input  logic [31:0] pc,
  input  logic        ecall,
  input  logic        mret,
  output logic [31:0] redirect_pc,
  output logic        redirect_valid,
  output logic [1:0]  priv,
  output logic        illegal
);
  localparam logic [1:0] LVL_U = 2'b00;
  localparam logic [1:0] LVL_M = 2'b11;
  localparam logic [11:0] A_STAT = 12'h300, A_ISA = 12'h301, A_IEN = 12'h304,
                          A_VEC = 12'h305, A_EPC = 12'h341, A_CAUSE = 12'h342,
                          A_TVAL = 12'h343, A_IPEND = 12'h344, A_VEND = 12'hF11,
                          A_ARCH = 12'hF12, A_IMPL = 12'hF13, A_HART = 12'hF14;

  logic [1:0]  lvl_q, ppl_q;
  logic        ien_q, pien_q;
  logic [31:0] epc_q, cause_q, tval_q, vec_q, ienreg_q, ipend_q;
  logic        rv_q, ill_q;
  logic [31:0] rpc_q;
  logic [31:0] rd_val, stat_val;

  wire        in_m     = (lvl_q == LVL_M);
  wire        bad_ret  = mret && !in_m && !exc_req && !ecall;
  wire        good_ret = mret && in_m && !exc_req && !ecall;
  wire        take     = exc_req || ecall || bad_ret;
  wire        do_wr    = csr_we && !take && !good_ret;
  wire [31:0] t_cause  = exc_req ? exc_cause : ecall ? (in_m ? 32'd11 : 32'd8) : 32'd2;
  wire [31:0] t_val    = exc_req ? exc_tval : 32'd0;
  wire [31:0] vbase    = {vec_q[31:2], 2'b00};
  wire [31:0] target   = (vec_q[1:0] == 2'b01 && t_cause[31]) ?
                         vbase + {t_cause[29:0], 2'b00} : vbase;

  always_comb begin
    stat_val = '0;
    stat_val[3] = ien_q;
    stat_val[7] = pien_q;
    stat_val[12:11] = ppl_q;
    case (csr_addr)
      A_STAT:  rd_val = stat_val;
      A_ISA:   rd_val = ISA_WORD;
      A_IEN:   rd_val = ienreg_q;
      A_VEC:   rd_val = vec_q;
      A_EPC:   rd_val = epc_q;
      A_CAUSE: rd_val = cause_q;
      A_TVAL:  rd_val = tval_q;
      A_IPEND: rd_val = ipend_q;
      A_IMPL:  rd_val = IMPL_ID;
      A_HART:  rd_val = HART_ID;
      default: rd_val = '0;
    endcase
  end

  assign csr_rdata      = csr_re ? rd_val : '0;
  assign redirect_pc    = rpc_q;
  assign redirect_valid = rv_q;
  assign priv           = lvl_q;
  assign illegal        = ill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LVL_M; ppl_q <= LVL_U; ien_q <= 1'b0; pien_q <= 1'b0;
      epc_q <= '0; cause_q <= '0; tval_q <= '0; vec_q <= '0;
      ienreg_q <= '0; ipend_q <= '0;
      rv_q <= 1'b0; ill_q <= 1'b0; rpc_q <= '0;
    end else begin
      rv_q  <= take || good_ret;
      ill_q <= bad_ret;
      if (take) begin
        epc_q   <= pc;
        cause_q <= t_cause;
        tval_q  <= t_val;
        pien_q  <= ien_q;
        ien_q   <= 1'b0;
        ppl_q   <= lvl_q;
        lvl_q   <= LVL_M;
        rpc_q   <= target;
      end else if (good_ret) begin
        ien_q  <= pien_q;
        pien_q <= 1'b1;
        lvl_q  <= ppl_q;
        ppl_q  <= LVL_U;
        rpc_q  <= epc_q;
      end else if (do_wr) begin
        case (csr_addr)
          A_STAT: begin
            ien_q  <= csr_wdata[3];
            pien_q <= csr_wdata[7];
            ppl_q  <= (csr_wdata[12:11] == LVL_M) ? LVL_M : LVL_U;
          end
          A_IEN:   ienreg_q <= csr_wdata;
          A_VEC:   vec_q    <= csr_wdata;
          A_EPC:   epc_q    <= csr_wdata;
          A_CAUSE: cause_q  <= csr_wdata;
          A_TVAL:  tval_q   <= csr_wdata;
          A_IPEND: ipend_q  <= csr_wdata;
          default: ;
        endcase
      end
    end
  end

  assert_trap_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (priv == LVL_M) && redirect_valid && !ien_q && epc_q == $past(pc));

  assert_ecall_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ecall && !exc_req && priv == LVL_U) |=> cause_q == 32'd8);

  assert_ret_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && priv == LVL_M && !exc_req && !ecall) |=> redirect_pc == $past(epc_q));

  assert_illegal_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cause_q == 32'd2) && (priv == LVL_M) && redirect_valid);

  assert_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && csr_we && csr_addr == A_TVAL) |=> tval_q == $past(exc_tval));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req || ecall || mret) |=> !redirect_valid);
endmodule

// File: tb/mtrap_csr_unit_tb.sv
`timescale 1ns/1ps
module mtrap_csr_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, exc_cause = '0, exc_tval = '0, pc = '0;
  logic csr_we = 0, csr_re = 0, exc_req = 0, ecall = 0, mret = 0;
  logic [31:0] csr_rdata, redirect_pc;
  logic redirect_valid, illegal;
  logic [1:0] priv;

  always #2 clk = ~clk;

  mtrap_csr_unit dut_i (.clk, .rst_n, .csr_addr, .csr_wdata, .csr_we, .csr_re,
    .csr_rdata, .exc_req, .exc_cause, .exc_tval, .pc, .ecall, .mret,
    .redirect_pc, .redirect_valid, .priv, .illegal);

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [1:0] m_lvl = 3, m_ppl = 0;
  logic m_ien = 0, m_pien = 0, m_rv = 0, m_ill = 0;
  logic [31:0] m_epc = 0, m_cause = 0, m_tval = 0, m_vec = 0, m_ienreg = 0, m_ipend = 0, m_rpc = 0;

  function automatic logic [31:0] m_read(logic [11:0] a, logic re);
    logic [31:0] s = 0;
    if (!re) return 0;
    s[3] = m_ien; s[7] = m_pien; s[12:11] = m_ppl;
    case (a)
      12'h300: return s;
      12'h301: return 32'h4010_0100;
      12'h304: return m_ienreg;
      12'h305: return m_vec;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      12'h344: return m_ipend;
      12'hF13: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic m_trap(logic [31:0] c, logic [31:0] tv);
    logic [31:0] base = {m_vec[31:2], 2'b00};
    m_rpc = (m_vec[1:0] == 1 && c[31]) ? base + 4 * c[30:0] : base;
    m_epc = pc; m_cause = c; m_tval = tv;
    m_pien = m_ien; m_ien = 0; m_ppl = m_lvl; m_lvl = 3; m_rv = 1;
  endtask

  task automatic step(string tag);
    check(tag, "rdata", csr_rdata, m_read(csr_addr, csr_re));
    @(posedge clk);
    m_rv = 0; m_ill = 0;
    if (exc_req) m_trap(exc_cause, exc_tval);
    else if (ecall) m_trap(m_lvl == 0 ? 8 : 11, 0);
    else if (mret && m_lvl != 3) begin m_trap(2, 0); m_ill = 1; end
    else if (mret) begin
      m_ien = m_pien; m_pien = 1; m_lvl = m_ppl; m_ppl = 0; m_rpc = m_epc; m_rv = 1;
    end else if (csr_we) begin
      case (csr_addr)
        12'h300: begin m_ien = csr_wdata[3]; m_pien = csr_wdata[7];
                       m_ppl = (csr_wdata[12:11] == 3) ? 2'd3 : 2'd0; end
        12'h304: m_ienreg = csr_wdata;
        12'h305: m_vec = csr_wdata;
        12'h341: m_epc = csr_wdata;
        12'h342: m_cause = csr_wdata;
        12'h343: m_tval = csr_wdata;
        12'h344: m_ipend = csr_wdata;
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag, "redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
    check(tag, "priv", {30'b0, priv}, {30'b0, m_lvl});
    check(tag, "illegal", {31'b0, illegal}, {31'b0, m_ill});
    if (m_rv) check(tag, "redirect_pc", redirect_pc, m_rpc);
    exc_req = 0; ecall = 0; mret = 0; csr_we = 0; csr_re = 0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic re = 1);
    csr_addr = a; csr_re = re; #1; step(tag);
  endtask
  task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1; #1; step(tag);
  endtask
  task automatic exc(string tag, logic [31:0] c, logic [31:0] tv, logic [31:0] p);
    exc_req = 1; exc_cause = c; exc_tval = tv; pc = p; #1; step(tag);
  endtask
  task automatic env(string tag, logic [31:0] p);
    ecall = 1; pc = p; #1; step(tag);
  endtask
  task automatic ret(string tag, logic [31:0] p);
    mret = 1; pc = p; #1; step(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    check("R1", "priv", {30'b0, priv}, 32'd3);
    check("R1", "redirect_valid", {31'b0, redirect_valid}, 0);
    check("R1", "illegal", {31'b0, illegal}, 0);
    foreach (m_epc[i]) if (i < 1) ;
    rd("R1", 12'h300); rd("R1", 12'h304); rd("R1", 12'h305); rd("R1", 12'h341);
    rd("R1", 12'h342); rd("R1", 12'h343); rd("R1", 12'h344);
    // R2 constant map and read enable
    rd("R2", 12'h301); rd("R2", 12'hF11); rd("R2", 12'hF12); rd("R2", 12'hF13);
    rd("R2", 12'hF14); rd("R2", 12'h7C0); rd("R2", 12'hF13, 0); rd("R2", 12'h301, 0);
    // R3 writes and status masking
    wr("R3", 12'h300, 32'hFFFF_FFFF); rd("R3", 12'h300);
    wr("R3", 12'h300, 32'h0000_0800); rd("R3", 12'h300);
    wr("R3", 12'h300, 32'h0000_1000); rd("R3", 12'h300);
    wr("R3", 12'h305, 32'h0000_0100); wr("R3", 12'h341, 32'h0000_055C);
    wr("R3", 12'h304, 32'h0000_0ABC); wr("R3", 12'h344, 32'h0000_0888);
    wr("R3", 12'h342, 32'hCAFE_0001); wr("R3", 12'h343, 32'h1357_9BDF);
    rd("R3", 12'h305); rd("R3", 12'h341); rd("R3", 12'h304); rd("R3", 12'h344);
    rd("R3", 12'h342); rd("R3", 12'h343);
    // R4 trap entry, enable clear and enable set
    exc("R4", 5, 32'hDEAD_BEEF, 32'h40);
    rd("R4", 12'h341); rd("R4", 12'h342); rd("R4", 12'h343); rd("R4", 12'h300);
    wr("R4", 12'h300, 32'h8);
    exc("R4", 7, 32'h11, 32'h80);
    rd("R4", 12'h300); rd("R4", 12'h341);
    // R7 return in machine mode
    ret("R7", 32'h84); rd("R7", 12'h300);
    wr("R7", 12'h300, 32'h80); wr("R7", 12'h341, 32'h200);
    ret("R7", 32'h88); rd("R7", 12'h300);
    // R6 environment call from user
    env("R6", 32'h204); rd("R6", 12'h342); rd("R6", 12'h343); rd("R6", 12'h300);
    ret("R7", 32'h100);
    // R8 return from user mode
    ret("R8", 32'h208); rd("R8", 12'h342); rd("R8", 12'h343); rd("R8", 12'h341); rd("R8", 12'h300);
    // R6 environment call from machine
    env("R6", 32'h300); rd("R6", 12'h342);
    // R5 vectored and direct targets
    wr("R5", 12'h305, 32'h0000_0201);
    exc("R5", 32'h8000_0003, 0, 32'h10);
    exc("R5", 32'h0000_0002, 0, 32'h14);
    exc("R5", 32'h8000_000B, 0, 32'h18);
    wr("R5", 12'h305, 32'h0000_0300);
    exc("R5", 32'h8000_0003, 0, 32'h1C);
    wr("R5", 12'h305, 32'h0000_0402);
    exc("R5", 32'h8000_0005, 0, 32'h20);
    // R9 priority and dropped writes
    exc_req = 1; exc_cause = 4; exc_tval = 32'hAAAA; ecall = 1; mret = 1;
    csr_we = 1; csr_addr = 12'h343; csr_wdata = 32'h1234; pc = 32'h500; #1; step("R9");
    rd("R9", 12'h343); rd("R9", 12'h342);
    ecall = 1; mret = 1; csr_we = 1; csr_addr = 12'h341; csr_wdata = 32'h9999; pc = 32'h600;
    #1; step("R9");
    rd("R9", 12'h341); rd("R9", 12'h342);
    mret = 1; csr_we = 1; csr_addr = 12'h305; csr_wdata = 32'h7770; pc = 32'h700;
    #1; step("R9");
    rd("R9", 12'h305);
    // R10 no redirect while idle
    rd("R10", 12'h000); rd("R10", 12'h000); rd("R10", 12'h300);
    finish_run();
  end
endmodule